// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit linear address into a 24-bit physical address by walking a two-level translation structure held in memory. A requester presents a linear address and a read/write flag. The walker reads one entry from the directory that the base register points to, and then one entry from the page table that the directory entry names. It checks the Present bit at each level. It then returns either the physical address or a fault. A fault carries the level at which translation stopped and also loads the fault-address register.

While it walks, the walker keeps the usage bookkeeping in memory up to date. The Accessed flag is set in both entries. The Dirty flag is set in the final-level entry when the request is a write. Each update is a read followed by a write to the same word on a single-access valid/ready memory port, and a bus lock is held across the pair. If the flags already have the required values, no write is issued. Writing the directory base register also raises a one-cycle flush strobe for any translation cache that sits outside this block.

Top module: `xlat_walker`

## Requirements
- R1: The directory entry is read from address {base frame[11:0], lin[31:22], 2'b00}. The table entry is then read from {directory entry[23:12], lin[21:12], 2'b00}. Entry bits 31..24 never reach the address.
- R2: A successful walk returns rsp_paddr = {table entry[23:12], lin[11:0]} with rsp_fault = 0.
- R3: If bit 0 (Present) of the directory entry is 0, the response has rsp_fault = 1 and rsp_level = 0. The table entry is not read and nothing is written.
- R4: If bit 0 of the table entry is 0, the response has rsp_fault = 1 and rsp_level = 1, and the table entry is not written. For either level of fault, fault_addr holds the full 32-bit linear address once the response is seen.
- R5: If a present directory entry has bit 5 (Accessed) clear, the walker writes it back with bit 5 set and all other bits unchanged. Bit 6 of a directory entry is never altered.
- R6: A present table entry is written back with bit 5 set. Bit 6 (Dirty) is set only for write requests (req_wr = 1). A read request leaves bit 6 as it was.
- R7: Every write-back goes to the address that was just read, and mem_lock stays high without a break from that read to the end of the write.
- R8: No write is issued for an entry whose required flags are already set: bit 5 for either level, and bit 6 as well for a table entry on a write request.
- R9: A pulse on base_we loads base_frame as physical bits 23..12 of the directory base. flush is high in the single cycle after the write and low otherwise.
- R10: On success, rsp_rw and rsp_us equal bits 1 and 2 of the table entry as read.
- R11: While mem_valid is high and mem_ready is low, the next cycle keeps mem_valid high with mem_addr, mem_we and mem_wdata unchanged.
- R12: req_ready is high only when the walker is idle. Each accepted request produces exactly one single-cycle rsp_valid pulse, after which req_ready is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_lin | input | 32 | Linear address to translate |
| req_wr | input | 1 | 1 = the translated access is a write |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation stopped on a non-present entry |
| rsp_level | output | 1 | Fault level: 0 directory, 1 table |
| rsp_paddr | output | 24 | Translated physical address |
| rsp_rw | output | 1 | Table entry bit 1 |
| rsp_us | output | 1 | Table entry bit 2 |
| mem_valid | output | 1 | Memory access requested |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Bus lock for read-modify-write |
| mem_addr | output | 24 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready on a read |
| base_we | input | 1 | Load directory base |
| base_frame | input | 12 | Directory base, physical bits 23..12 |
| flush | output | 1 | Translation cache invalidate strobe |
| fault_addr | output | 32 | Linear address of the last fault |

## Verification
A corrupted walk state shows up at the memory port during the same request. Examples are a read from the wrong level's address, a write with no read before it, or a write that lands while the lock is low. The bench observes each of these within the cycles of a single walk. A stale or mis-merged entry register shows up either as a flag changed in memory or as a wrong frame in rsp_paddr. The bench sees these when the response pulse arrives, a few memory handshakes after the request. A wrong fault decision changes how many reads happen and what rsp_fault and rsp_level report, and it shows in that same response.

// File: rtl/xlat_pkg.sv
// Package: shared constants and state encoding for the translation walker.
// Assumes 32-bit table entries with flag bits at fixed positions.
package xlat_pkg;
    localparam int ENT_W = 32;
    localparam int BIT_P  = 0;
    localparam int BIT_RW = 1;
    localparam int BIT_US = 2;
    localparam int BIT_A  = 5;
    localparam int BIT_D  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WR,
        ST_TBL_RD,
        ST_TBL_WR,
        ST_DONE
    } walk_st_e;
endpackage

// File: rtl/xlat_entry_upd.sv
// Entry updater: decides whether an entry just read is usable and whether
// it needs its status flags written back, and forms the new value.
// Assumes: purely combinational; want_dirty is only raised for last-level
// entries of write requests.
module xlat_entry_upd
    import xlat_pkg::*;
(
    input  logic [ENT_W-1:0] entry,
    input  logic             want_dirty,
    output logic             present,
    output logic             need_wb,
    output logic [ENT_W-1:0] new_entry
);
    logic [ENT_W-1:0] set_mask;

    // Build the flag mask and compare it with what is already set.
    always_comb begin
        set_mask        = '0;
        set_mask[BIT_A] = 1'b1;
        set_mask[BIT_D] = want_dirty;
        present         = entry[BIT_P];
        new_entry       = entry | set_mask;
        need_wb         = present && ((entry & set_mask) != set_mask);
    end
endmodule

// File: rtl/xlat_ctl_regs.sv
// Control registers: directory base, flush strobe and fault address.
// Assumes: fault_set is a single-cycle strobe from the walk controller.
module xlat_ctl_regs #(
    parameter int FRM_W = 12,
    parameter int LA_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_we,
    input  logic [FRM_W-1:0] base_frame,
    input  logic             fault_set,
    input  logic [LA_W-1:0]  fault_lin,
    output logic [FRM_W-1:0] base_q,
    output logic             flush,
    output logic [LA_W-1:0]  fault_addr
);
    // Directory base frame register.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_we) base_q <= base_frame;
    end

    // One-cycle flush strobe following each base write.
    always_ff @(posedge clk) begin
        if (!rst_n) flush <= 1'b0;
        else        flush <= base_we;
    end

    // Capture of the faulting linear address.
    always_ff @(posedge clk) begin
        if (!rst_n)         fault_addr <= '0;
        else if (fault_set) fault_addr <= fault_lin;
    end
endmodule

// File: rtl/xlat_walker.sv
// Two-level translation walker. It reads the directory entry and then the
// table entry, checks Present, writes Accessed/Dirty back under bus lock,
// and returns a 24-bit physical address or a fault with its level.
// Assumes: the memory port takes one access at a time and returns read data
// together with mem_ready. The lock is raised for every entry read, because
// the need for an update is only known once the data arrives.
module xlat_walker
    import xlat_pkg::*;
#(
    parameter int PA_W  = 24,
    parameter int PG_SH = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_lin,
    input  logic              req_wr,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic              rsp_level,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_rw,
    output logic              rsp_us,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [PA_W-1:0]   mem_addr,
    output logic [ENT_W-1:0]  mem_wdata,
    input  logic [ENT_W-1:0]  mem_rdata,
    input  logic              base_we,
    input  logic [PA_W-PG_SH-1:0] base_frame,
    output logic              flush,
    output logic [31:0]       fault_addr
);
    localparam int IX_W   = PG_SH - 2;
    localparam int LA_W   = PG_SH + 2 * IX_W;
    localparam int FRM_W  = PA_W - PG_SH;
    localparam int DIR_LO = PG_SH + IX_W;

    walk_st_e         state;
    logic [LA_W-1:0]  q_lin;
    logic             q_wr;
    logic [ENT_W-1:0] q_ent;
    logic [PA_W-1:0]  q_addr;
    logic             q_we;
    logic [ENT_W-1:0] q_wdata;
    logic [FRM_W-1:0] base_q;

    logic             rd_dir, rd_tbl, rd_done;
    logic             upd_present, upd_need_wb;
    logic [ENT_W-1:0] upd_new;
    logic [ENT_W-1:0] tbl_src, fin_src;
    logic [PA_W-1:0]  tbl_addr;
    logic             fault_set;

    xlat_ctl_regs #(.FRM_W(FRM_W), .LA_W(LA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_we    (base_we),
        .base_frame (base_frame),
        .fault_set  (fault_set),
        .fault_lin  (q_lin),
        .base_q     (base_q),
        .flush      (flush),
        .fault_addr (fault_addr)
    );

    xlat_entry_upd u_upd (
        .entry      (mem_rdata),
        .want_dirty (rd_tbl && q_wr),
        .present    (upd_present),
        .need_wb    (upd_need_wb),
        .new_entry  (upd_new)
    );

    // Decode of the active read phase and its completion.
    always_comb begin
        rd_dir    = (state == ST_DIR_RD);
        rd_tbl    = (state == ST_TBL_RD);
        rd_done   = (rd_dir || rd_tbl) && mem_ready;
        fault_set = rd_done && !upd_present;
    end

    // Sources for the next-level address and the final frame.
    always_comb begin
        tbl_src  = rd_dir ? mem_rdata : q_ent;
        fin_src  = rd_tbl ? mem_rdata : q_ent;
        tbl_addr = {tbl_src[PA_W-1:PG_SH], q_lin[DIR_LO-1:PG_SH], 2'b00};
    end

    // Port outputs derived from the walk state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_DONE);
        mem_valid = (state == ST_DIR_RD) || (state == ST_DIR_WR) ||
                    (state == ST_TBL_RD) || (state == ST_TBL_WR);
        mem_lock  = mem_valid;
        mem_we    = q_we;
        mem_addr  = q_addr;
        mem_wdata = q_wdata;
    end

    // Walk sequencer with the memory request and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            q_lin     <= '0;
            q_wr      <= 1'b0;
            q_ent     <= '0;
            q_addr    <= '0;
            q_we      <= 1'b0;
            q_wdata   <= '0;
            rsp_fault <= 1'b0;
            rsp_level <= 1'b0;
            rsp_paddr <= '0;
            rsp_rw    <= 1'b0;
            rsp_us    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        q_lin  <= req_lin;
                        q_wr   <= req_wr;
                        q_we   <= 1'b0;
                        q_addr <= {base_q, req_lin[LA_W-1:DIR_LO], 2'b00};
                        state  <= ST_DIR_RD;
                    end
                end
                ST_DIR_RD, ST_TBL_RD: begin
                    if (mem_ready) begin
                        q_ent <= mem_rdata;
                        if (!upd_present) begin
                            rsp_fault <= 1'b1;
                            rsp_level <= rd_tbl;
                            rsp_paddr <= '0;
                            rsp_rw    <= 1'b0;
                            rsp_us    <= 1'b0;
                            state     <= ST_DONE;
                        end else if (upd_need_wb) begin
                            q_we    <= 1'b1;
                            q_wdata <= upd_new;
                            state   <= rd_dir ? ST_DIR_WR : ST_TBL_WR;
                        end else if (rd_dir) begin
                            q_addr <= tbl_addr;
                            state  <= ST_TBL_RD;
                        end else begin
                            rsp_fault <= 1'b0;
                            rsp_level <= 1'b0;
                            rsp_paddr <= {fin_src[PA_W-1:PG_SH], q_lin[PG_SH-1:0]};
                            rsp_rw    <= fin_src[BIT_RW];
                            rsp_us    <= fin_src[BIT_US];
                            state     <= ST_DONE;
                        end
                    end
                end
                ST_DIR_WR: begin
                    if (mem_ready) begin
                        q_we   <= 1'b0;
                        q_addr <= tbl_addr;
                        state  <= ST_TBL_RD;
                    end
                end
                ST_TBL_WR: begin
                    if (mem_ready) begin
                        q_we      <= 1'b0;
                        rsp_fault <= 1'b0;
                        rsp_level <= 1'b0;
                        rsp_paddr <= {fin_src[PA_W-1:PG_SH], q_lin[PG_SH-1:0]};
                        rsp_rw    <= fin_src[BIT_RW];
                        rsp_us    <= fin_src[BIT_US];
                        state     <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xlat_walker_chk.sv
// Checker for the translation walker: port-level timing rules.
// Assumes it is bound to every instance of xlat_walker.
module xlat_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic        mem_we,
    input logic        mem_lock,
    input logic [23:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        base_we,
    input logic        flush
);
    // A write-back only happens under lock and right after a locked cycle.
    p_wr_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> (mem_lock && $past(mem_lock)));

    // A write-back always carries the Accessed flag.
    p_wb_accessed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> mem_wdata[5]);

    // A stalled request stays put.
    p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
        (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // Entry accesses are word aligned.
    p_word_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[1:0] == 2'b00));

    // Base write is followed by a flush strobe.
    p_flush_after_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |=> flush);

    // Response is a single-cycle pulse and never overlaps request acceptance.
    p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    p_rsp_not_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
endmodule

bind xlat_walker xlat_walker_chk u_chk (.*);

// File: tb/xlat_walker_tb.sv
// Bench for the translation walker: a vector table of entries walked by one
// loop, then directed reset, base/flush and hold checks.
module xlat_walker_tb;
    localparam int PERIOD = 10;

    typedef struct packed {
        logic [31:0] lin;
        logic        wr;
        logic [31:0] pde;
        logic [31:0] pte;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0040_1234, 1'b0, 32'h0003_5027, 32'h0078_9023},
        '{32'h8060_2ABC, 1'b1, 32'h0004_1001, 32'h00AB_C005},
        '{32'h1230_0FFF, 1'b0, 32'h0005_0026, 32'h0011_1001},
        '{32'h2010_3004, 1'b1, 32'h0006_1021, 32'hDEAD_B00E},
        '{32'h3FC0_4100, 1'b0, 32'h0007_1061, 32'h1234_5067},
        '{32'h4000_5008, 1'b1, 32'h0008_1021, 32'h0012_3023},
        '{32'h5000_6010, 1'b1, 32'h0009_1021, 32'h0012_3063},
        '{32'h6000_7020, 1'b0, 32'h000A_1001, 32'h0055_5001},
        '{32'h7000_8777, 1'b1, 32'hFF0F_F021, 32'hABCD_E007}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        req_wr = 1'b0;
    logic        rsp_valid, rsp_fault, rsp_level, rsp_rw, rsp_us;
    logic [23:0] rsp_paddr;
    logic        mem_valid, mem_we, mem_lock;
    logic        mem_ready;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        base_we = 1'b0;
    logic [11:0] base_frame = '0;
    logic        flush;
    logic [31:0] fault_addr;

    int checks = 0;
    int errs = 0;

    // Memory model: two loadable slots, ready pattern from a counter.
    logic [23:0] ld_a0 = '0, ld_a1 = '0;
    logic [31:0] ld_d0 = '0, ld_d1 = '0;
    logic        ld_go = 1'b0, clr = 1'b0;
    logic [23:0] sl_a0 = '0, sl_a1 = '0;
    logic [31:0] sl_d0 = '0, sl_d1 = '0;
    logic [1:0]  rdy_cnt = '0;

    int          rd_cnt = 0, wr_cnt = 0, lock_err = 0, hold_err = 0;
    logic [23:0] rd_log0 = '0, rd_log1 = '0, last_rd = '0, hold_addr = '0;
    logic        lock_run = 1'b0, hold_pend = 1'b0, hold_we = 1'b0;

    xlat_walker u_dut (.*);

    always #(PERIOD/2) clk = ~clk;

    assign mem_ready = (rdy_cnt != 2'd1);

    always_comb begin
        mem_rdata = 32'h0;
        if (mem_addr == sl_a0)      mem_rdata = sl_d0;
        else if (mem_addr == sl_a1) mem_rdata = sl_d1;
    end

    always @(posedge clk) begin
        rdy_cnt <= (rdy_cnt == 2'd2) ? 2'd0 : rdy_cnt + 2'd1;
        if (ld_go) begin
            sl_a0 <= ld_a0; sl_d0 <= ld_d0; sl_a1 <= ld_a1; sl_d1 <= ld_d1;
        end else if (mem_valid && mem_ready && mem_we) begin
            if (mem_addr == sl_a0)      sl_d0 <= mem_wdata;
            else if (mem_addr == sl_a1) sl_d1 <= mem_wdata;
        end
    end

    // Bus monitor: read/write counts, lock continuity, request hold.
    always @(posedge clk) begin
        if (clr) begin
            rd_cnt <= 0; wr_cnt <= 0; lock_err <= 0; hold_err <= 0;
            lock_run <= 1'b0; hold_pend <= 1'b0;
        end else begin
            if (hold_pend && (!mem_valid || mem_addr != hold_addr || mem_we != hold_we))
                hold_err <= hold_err + 1;
            hold_pend <= mem_valid && !mem_ready;
            hold_addr <= mem_addr;
            hold_we   <= mem_we;
            if (mem_valid && mem_ready && !mem_we) begin
                if (rd_cnt == 0) rd_log0 <= mem_addr;
                if (rd_cnt == 1) rd_log1 <= mem_addr;
                rd_cnt   <= rd_cnt + 1;
                last_rd  <= mem_addr;
                lock_run <= mem_lock;
            end else if (!mem_lock) begin
                lock_run <= 1'b0;
            end
            if (mem_valid && mem_ready && mem_we) begin
                wr_cnt <= wr_cnt + 1;
                if (!(lock_run && mem_lock && mem_addr == last_rd))
                    lock_err <= lock_err + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Run one walk against a vector and compare with the requirement model.
    task automatic run_walk(input vec_t v, input logic [11:0] bframe);
        logic [23:0] pde_a, pte_a;
        logic        dir_ok, tbl_ok, need_t;
        logic [31:0] exp_pde, exp_pte;
        int          exp_wr, exp_rd, n;
        pde_a   = {bframe, v.lin[31:22], 2'b00};
        pte_a   = {v.pde[23:12], v.lin[21:12], 2'b00};
        dir_ok  = v.pde[0];
        tbl_ok  = dir_ok && v.pte[0];
        need_t  = !v.pte[5] || (v.wr && !v.pte[6]);
        exp_pde = dir_ok ? (v.pde | 32'h20) : v.pde;
        exp_pte = tbl_ok ? (v.pte | 32'h20 | (v.wr ? 32'h40 : 32'h0)) : v.pte;
        exp_wr  = ((dir_ok && !v.pde[5]) ? 1 : 0) + ((tbl_ok && need_t) ? 1 : 0);
        exp_rd  = dir_ok ? 2 : 1;

        @(negedge clk);
        ld_a0 = pde_a; ld_d0 = v.pde; ld_a1 = pte_a; ld_d1 = v.pte;
        ld_go = 1'b1; clr = 1'b1;
        @(negedge clk);
        ld_go = 1'b0; clr = 1'b0;
        chk(req_ready == 1'b1, "R12", "ready when idle", {31'b0, req_ready}, 32'h1);
        req_valid = 1'b1; req_lin = v.lin; req_wr = v.wr;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(rsp_valid == 1'b1, "R12", "response arrives", {31'b0, rsp_valid}, 32'h1);
        chk(rsp_fault == !tbl_ok, "R3", "fault flag", {31'b0, rsp_fault}, {31'b0, !tbl_ok});
        chk(rd_cnt == exp_rd, "R3", "entry reads", rd_cnt, exp_rd);
        chk(rd_log0 == pde_a, "R1", "directory address", {8'b0, rd_log0}, {8'b0, pde_a});
        if (dir_ok)
            chk(rd_log1 == pte_a, "R1", "table address", {8'b0, rd_log1}, {8'b0, pte_a});
        if (!tbl_ok) begin
            chk(rsp_level == dir_ok, "R4", "fault level", {31'b0, rsp_level}, {31'b0, dir_ok});
            chk(fault_addr == v.lin, "R4", "fault address", fault_addr, v.lin);
        end else begin
            chk(rsp_paddr == {v.pte[23:12], v.lin[11:0]}, "R2", "physical address",
                {8'b0, rsp_paddr}, {8'b0, v.pte[23:12], v.lin[11:0]});
            chk({rsp_us, rsp_rw} == v.pte[2:1], "R10", "rw/us bits",
                {30'b0, rsp_us, rsp_rw}, {30'b0, v.pte[2:1]});
        end
        chk(sl_d0 == exp_pde, "R5", "directory entry after walk", sl_d0, exp_pde);
        chk(sl_d1 == exp_pte, "R6", "table entry after walk", sl_d1, exp_pte);
        chk(wr_cnt == exp_wr, "R8", "write-back count", wr_cnt, exp_wr);
        chk(lock_err == 0, "R7", "locked read-modify-write", lock_err, 0);
        chk(hold_err == 0, "R11", "request held while stalled", hold_err, 0);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R12", "single pulse then idle",
            {30'b0, rsp_valid, req_ready}, 32'h1);
    endtask

    // Watchdog: a hung run still reaches the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_valid && !flush, "R12", "reset outputs",
            {28'b0, req_ready, rsp_valid, mem_valid, flush}, 32'h8);
        chk(fault_addr == 32'h0, "R4", "reset fault address", fault_addr, 32'h0);

        // R9: base write and flush strobe.
        base_we = 1'b1; base_frame = 12'h012;
        @(negedge clk);
        base_we = 1'b0;
        chk(flush == 1'b1, "R9", "flush after base write", {31'b0, flush}, 32'h1);
        @(negedge clk);
        chk(flush == 1'b0, "R9", "flush one cycle", {31'b0, flush}, 32'h0);

        for (int i = 0; i < NV; i++) run_walk(VECS[i], 12'h012);

        // R9: new base steers the directory read.
        @(negedge clk);
        base_we = 1'b1; base_frame = 12'hCDE;
        @(negedge clk);
        base_we = 1'b0;
        chk(flush == 1'b1, "R9", "flush on second base write", {31'b0, flush}, 32'h1);
        run_walk(VECS[1], 12'hCDE);
        chk(flush == 1'b0, "R9", "no flush without base write", {31'b0, flush}, 32'h0);

        // R6: same page read then written: dirty only on the write.
        run_walk('{32'h0C40_9010, 1'b0, 32'h0002_3021, 32'h0044_4021}, 12'hCDE);
        run_walk('{32'h0C40_9010, 1'b1, 32'h0002_3021, 32'h0044_4021}, 12'hCDE);

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule